// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block drives a data mover with byte addresses for a transfer arranged in three levels. An array is a run of contiguous bytes. A frame is a number of arrays. A block is a number of frames. The source side and the destination side each have their own base address, their own array stride and their own frame stride. The sequencer steps both sides together and issues one source/destination byte-address pair per clock cycle.

Software arms the channel by pulsing `arm_i` while the three lengths, the two bases, the four strides and the sync mode are valid on the inputs. Each later sync trigger on `trig_i` starts one unit of work. In array-sync mode a unit is one array. In frame-sync mode a unit is one whole frame. At the end of every unit a done pulse is raised. The block-complete pulse is raised only at the end of the last unit. After it the channel returns to idle. A trigger that arrives while a unit is still being issued starts nothing. It sets a sticky missed-event flag instead.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset, `vld_o`, `unit_done_o`, `xfer_done_o` and `missed_o` are 0. Until the channel is armed, triggers produce no pairs and do not set `missed_o`.
- R2: An arm pulse loads the configuration only if all three lengths are nonzero. If any length is zero, the channel is left idle, so a following trigger produces no pairs and no done pulse.
- R3: The first pair appears with `vld_o`=1 in the cycle after the edge that accepts a trigger. Within an array, each next cycle carries both addresses incremented by one.
- R4: Byte b of array j in frame k has address base + k·frame_stride + j·array_stride + b on each side, modulo 2^32. Both strides are 16-bit two's-complement values, sign-extended.
- R5: With `sync_mode_i`=0 (array sync), each accepted trigger issues exactly `arr_len_i` pairs. The frame stride is applied after the last array of a frame.
- R6: With `sync_mode_i`=1 (frame sync), each accepted trigger issues exactly `arr_len_i`·`frm_len_i` pairs.
- R7: `unit_done_o` is a one-cycle pulse in the cycle right after the last pair of every unit, including units after the first. In that cycle `vld_o` is 0.
- R8: `xfer_done_o` pulses together with the `unit_done_o` of the final unit of the block. After that, triggers produce no pairs and leave `missed_o` unchanged until the next arm.
- R9: A trigger seen while pairs are being issued sets `missed_o` from the next cycle on. It does not alter the running sequence of pairs.
- R10: `missed_o` stays set until `evt_clr_i`, which clears it in the following cycle. If a miss and a clear occur in the same cycle, the flag stays set.
- R11: An arm pulse while pairs are being issued is ignored. The running block continues with its original configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Load configuration and arm the channel |
| sync_mode_i | input | 1 | 0 = one array per trigger, 1 = one frame per trigger |
| arr_len_i | input | 16 | Bytes per array |
| frm_len_i | input | 16 | Arrays per frame |
| blk_len_i | input | 16 | Frames per block |
| src_base_i | input | 32 | Source start byte address |
| dst_base_i | input | 32 | Destination start byte address |
| src_arr_stride_i | input | 16 | Signed source step between arrays |
| dst_arr_stride_i | input | 16 | Signed destination step between arrays |
| src_frm_stride_i | input | 16 | Signed source step between frames |
| dst_frm_stride_i | input | 16 | Signed destination step between frames |
| trig_i | input | 1 | Sync trigger |
| evt_clr_i | input | 1 | Synchronous clear of the missed-event flag |
| vld_o | output | 1 | Address pair valid |
| src_addr_o | output | 32 | Source byte address |
| dst_addr_o | output | 32 | Destination byte address |
| unit_done_o | output | 1 | Pulse at the end of each triggered unit |
| xfer_done_o | output | 1 | Pulse at the end of the whole block |
| missed_o | output | 1 | Sticky missed-trigger flag |

## Verification
The hardest cases to reach are those where a second event lands in the middle of a running unit: a trigger, a trigger together with a clear, or a new arm carrying different bases. The stimulus handles this by injecting the event at a chosen pair index while it compares the address stream cycle by cycle. It then checks that the stream is unchanged and reads the flag afterwards. Frame-stride wraparound with negative strides is reached by sweeping every small combination of the three lengths in both modes, with two stride sets.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READY, ST_RUN} seq_state_e;
  typedef enum logic {SYNC_ARRAY = 1'b0, SYNC_FRAME = 1'b1} sync_mode_e;
endpackage

// File: rtl/dma3d_ctrl.sv
module dma3d_ctrl
  import dma3d_pkg::*;
#(
  parameter int CNT_A_W = 16,
  parameter int CNT_B_W = 16,
  parameter int CNT_C_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic               trig_i,
  input  logic               mode_i,
  input  logic [CNT_A_W-1:0] arr_len_i,
  input  logic [CNT_B_W-1:0] frm_len_i,
  input  logic [CNT_C_W-1:0] blk_len_i,
  output logic               load_o,
  output logic               run_o,
  output logic [CNT_A_W-1:0] byte_idx_o,
  output logic               byte_last_o,
  output logic               arr_step_o,
  output logic               frm_step_o,
  output logic               unit_done_o,
  output logic               xfer_done_o,
  output logic               trig_miss_o
);
  seq_state_e         state_q;
  sync_mode_e         mode_q;
  logic [CNT_A_W-1:0] a_len_q, byte_q;
  logic [CNT_B_W-1:0] b_len_q, arr_q;
  logic [CNT_C_W-1:0] c_len_q, frm_q;
  logic               unit_q, xfer_q;
  logic               cnt_ok, not_run, run;
  logic               byte_last, arr_last, frm_last, unit_end, blk_end;

  assign cnt_ok    = (|arr_len_i) && (|frm_len_i) && (|blk_len_i);
  assign not_run   = (state_q != ST_RUN);
  assign run       = (state_q == ST_RUN);
  assign byte_last = (byte_q == a_len_q - 1'b1);
  assign arr_last  = (arr_q == b_len_q - 1'b1);
  assign frm_last  = (frm_q == c_len_q - 1'b1);
  assign unit_end  = byte_last && ((mode_q == SYNC_FRAME) ? arr_last : 1'b1);
  assign blk_end   = byte_last && arr_last && frm_last;

  assign load_o      = arm_i && not_run && cnt_ok;
  assign run_o       = run;
  assign byte_idx_o  = byte_q;
  assign byte_last_o = byte_last;
  assign arr_step_o  = run && byte_last && !arr_last;
  assign frm_step_o  = run && byte_last && arr_last && !frm_last;
  assign trig_miss_o = trig_i && run;
  assign unit_done_o = unit_q;
  assign xfer_done_o = xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= SYNC_ARRAY;
      a_len_q <= '0;
      b_len_q <= '0;
      c_len_q <= '0;
      byte_q  <= '0;
      arr_q   <= '0;
      frm_q   <= '0;
      unit_q  <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      unit_q <= run && unit_end;
      xfer_q <= run && blk_end;
      if (arm_i && not_run) begin
        if (cnt_ok) begin
          state_q <= ST_READY;
          mode_q  <= sync_mode_e'(mode_i);
          a_len_q <= arr_len_i;
          b_len_q <= frm_len_i;
          c_len_q <= blk_len_i;
          byte_q  <= '0;
          arr_q   <= '0;
          frm_q   <= '0;
        end else begin
          state_q <= ST_IDLE;
        end
      end else begin
        case (state_q)
          ST_READY: if (trig_i) state_q <= ST_RUN;
          ST_RUN: begin
            if (byte_last) begin
              byte_q <= '0;
              if (arr_last) begin
                arr_q <= '0;
                frm_q <= frm_last ? '0 : frm_q + 1'b1;
              end else begin
                arr_q <= arr_q + 1'b1;
              end
              if (unit_end) state_q <= blk_end ? ST_IDLE : ST_READY;
            end else begin
              byte_q <= byte_q + 1'b1;
            end
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int IDX_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [STRIDE_W-1:0] arr_stride_i,
  input  logic [STRIDE_W-1:0] frm_stride_i,
  input  logic                arr_step_i,
  input  logic                frm_step_i,
  input  logic [IDX_W-1:0]    byte_idx_i,
  output logic [ADDR_W-1:0]   addr_o
);
  localparam int SPAD = ADDR_W - STRIDE_W;
  localparam int IPAD = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] arr_q, frm_q, a_step_q, f_step_q, frm_next;

  assign frm_next = frm_q + f_step_q;
  assign addr_o   = arr_q + {{IPAD{1'b0}}, byte_idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_q    <= '0;
      frm_q    <= '0;
      a_step_q <= '0;
      f_step_q <= '0;
    end else if (load_i) begin
      arr_q    <= base_i;
      frm_q    <= base_i;
      a_step_q <= {{SPAD{arr_stride_i[STRIDE_W-1]}}, arr_stride_i};
      f_step_q <= {{SPAD{frm_stride_i[STRIDE_W-1]}}, frm_stride_i};
    end else if (frm_step_i) begin
      // next frame restarts from the frame origin, not the last array
      frm_q <= frm_next;
      arr_q <= frm_next;
    end else if (arr_step_i) begin
      arr_q <= arr_q + a_step_q;
    end
  end
endmodule

// File: rtl/dma3d_miss_flag.sv
module dma3d_miss_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int CNT_A_W  = 16,
  parameter int CNT_B_W  = 16,
  parameter int CNT_C_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                sync_mode_i,
  input  logic [CNT_A_W-1:0]  arr_len_i,
  input  logic [CNT_B_W-1:0]  frm_len_i,
  input  logic [CNT_C_W-1:0]  blk_len_i,
  input  logic [ADDR_W-1:0]   src_base_i,
  input  logic [ADDR_W-1:0]   dst_base_i,
  input  logic [STRIDE_W-1:0] src_arr_stride_i,
  input  logic [STRIDE_W-1:0] dst_arr_stride_i,
  input  logic [STRIDE_W-1:0] src_frm_stride_i,
  input  logic [STRIDE_W-1:0] dst_frm_stride_i,
  input  logic                trig_i,
  input  logic                evt_clr_i,
  output logic                vld_o,
  output logic [ADDR_W-1:0]   src_addr_o,
  output logic [ADDR_W-1:0]   dst_addr_o,
  output logic                unit_done_o,
  output logic                xfer_done_o,
  output logic                missed_o
);
  localparam int NSIDE = 2;

  logic               load, run, byte_last, arr_step, frm_step, trig_miss;
  logic [CNT_A_W-1:0] byte_idx;

  logic [NSIDE-1:0][ADDR_W-1:0]   side_base, side_addr;
  logic [NSIDE-1:0][STRIDE_W-1:0] side_astr, side_fstr;

  assign side_base = {dst_base_i, src_base_i};
  assign side_astr = {dst_arr_stride_i, src_arr_stride_i};
  assign side_fstr = {dst_frm_stride_i, src_frm_stride_i};

  dma3d_ctrl #(
    .CNT_A_W(CNT_A_W), .CNT_B_W(CNT_B_W), .CNT_C_W(CNT_C_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .trig_i      (trig_i),
    .mode_i      (sync_mode_i),
    .arr_len_i   (arr_len_i),
    .frm_len_i   (frm_len_i),
    .blk_len_i   (blk_len_i),
    .load_o      (load),
    .run_o       (run),
    .byte_idx_o  (byte_idx),
    .byte_last_o (byte_last),
    .arr_step_o  (arr_step),
    .frm_step_o  (frm_step),
    .unit_done_o (unit_done_o),
    .xfer_done_o (xfer_done_o),
    .trig_miss_o (trig_miss)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma3d_addr_gen #(
      .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .IDX_W(CNT_A_W)
    ) u_gen (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (load),
      .base_i       (side_base[s]),
      .arr_stride_i (side_astr[s]),
      .frm_stride_i (side_fstr[s]),
      .arr_step_i   (arr_step),
      .frm_step_i   (frm_step),
      .byte_idx_i   (byte_idx),
      .addr_o       (side_addr[s])
    );
  end

  dma3d_miss_flag u_miss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig_miss),
    .clr_i  (evt_clr_i),
    .flag_o (missed_o)
  );

  assign vld_o      = run;
  assign src_addr_o = side_addr[0];
  assign dst_addr_o = side_addr[1];
endmodule

// File: rtl/dma3d_addr_seq_chk.sv
module dma3d_addr_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_i,
  input logic              evt_clr_i,
  input logic              vld_o,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              unit_done_o,
  input logic              xfer_done_o,
  input logic              missed_o,
  input logic              byte_last
);
  p_byte_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !byte_last |=> vld_o && (src_addr_o == $past(src_addr_o) + ADDR_W'(1))
                                  && (dst_addr_o == $past(dst_addr_o) + ADDR_W'(1)));

  p_done_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_done_o |-> !vld_o);

  p_final_unit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> unit_done_o);

  p_idle_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o && trig_i && !missed_o |=> !vld_o && !missed_o);

  p_miss_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && vld_o |=> missed_o);

  p_miss_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missed_o && !evt_clr_i |=> missed_o);

  p_miss_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clr_i && !(trig_i && vld_o) |=> !missed_o);
endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_i),
  .evt_clr_i   (evt_clr_i),
  .vld_o       (vld_o),
  .src_addr_o  (src_addr_o),
  .dst_addr_o  (dst_addr_o),
  .unit_done_o (unit_done_o),
  .xfer_done_o (xfer_done_o),
  .missed_o    (missed_o),
  .byte_last   (byte_last)
);

// File: tb/dma3d_addr_seq_tb_top.sv
module dma3d_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, mode = 1'b0, trig = 1'b0, clr = 1'b0;
  logic [15:0] a_len = '0, b_len = '0, c_len = '0;
  logic [31:0] s_base = '0, d_base = '0;
  logic [15:0] s_as = '0, d_as = '0, s_fs = '0, d_fs = '0;
  logic        vld, u_done, x_done, missed;
  logic [31:0] s_addr, d_addr;

  int n_vec = 0, n_err = 0;
  int cur_k = 0, cur_j = 0;

  always #5 clk = ~clk;

  dma3d_addr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .sync_mode_i(mode),
    .arr_len_i(a_len), .frm_len_i(b_len), .blk_len_i(c_len),
    .src_base_i(s_base), .dst_base_i(d_base),
    .src_arr_stride_i(s_as), .dst_arr_stride_i(d_as),
    .src_frm_stride_i(s_fs), .dst_frm_stride_i(d_fs),
    .trig_i(trig), .evt_clr_i(clr),
    .vld_o(vld), .src_addr_o(s_addr), .dst_addr_o(d_addr),
    .unit_done_o(u_done), .xfer_done_o(x_done), .missed_o(missed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [15:0] as,
                                           input logic [15:0] fs, input int k, input int j,
                                           input int b);
    int ai = int'($signed(as));
    int fi = int'($signed(fs));
    return base + 32'(k * fi + j * ai + b);
  endfunction

  task automatic do_arm(input logic m, input int a, input int b, input int c,
                        input logic [15:0] sa, input logic [15:0] da,
                        input logic [15:0] sf, input logic [15:0] df);
    @(negedge clk);
    mode = m; a_len = 16'(a); b_len = 16'(b); c_len = 16'(c);
    s_base = 32'h1000_0000; d_base = 32'h0000_0010;
    s_as = sa; d_as = da; s_fs = sf; d_fs = df;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    cur_k = 0; cur_j = 0;
  endtask

  // one triggered unit; inj_* fire at pair index inj_at
  task automatic run_unit(input int n_arr, input logic last, input string req, input int inj_at,
                          input logic inj_trig, input logic inj_clr, input logic inj_arm);
    int idx = 0;
    logic [31:0] sb_keep = s_base;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    for (int a = 0; a < n_arr; a++) begin
      for (int b = 0; b < int'(a_len); b++) begin
        chk({req, " R3 vld"}, 32'(vld), 32'd1);
        chk({req, " R4 src"}, s_addr, exp_addr(sb_keep, s_as, s_fs, cur_k, cur_j, b));
        chk({req, " R4 dst"}, d_addr, exp_addr(32'h0000_0010, d_as, d_fs, cur_k, cur_j, b));
        if (idx == inj_at) begin
          trig = inj_trig; clr = inj_clr;
          if (inj_arm) begin arm = 1'b1; s_base = 32'hDEAD_0000; end
        end
        @(negedge clk);
        trig = 1'b0; clr = 1'b0; arm = 1'b0; s_base = sb_keep;
        idx++;
      end
      if (cur_j == int'(b_len) - 1) begin cur_j = 0; cur_k++; end
      else cur_j++;
    end
    chk({req, " R7 vld gap"}, 32'(vld), 32'd0);
    chk({req, " R7 unit_done"}, 32'(u_done), 32'd1);
    chk({req, " R8 xfer_done"}, 32'(x_done), 32'(last));
  endtask

  task automatic run_block(input string req);
    int units = mode ? int'(c_len) : int'(b_len) * int'(c_len);
    int per   = mode ? int'(b_len) : 1;
    for (int u = 0; u < units; u++)
      run_unit(per, (u == units - 1), req, -1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 no pairs after block", 32'(vld), 32'd0);
      chk("R8 missed untouched", 32'(missed), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and unarmed trigger
    chk("R1 vld", 32'(vld), 32'd0);
    chk("R1 unit_done", 32'(u_done), 32'd0);
    chk("R1 xfer_done", 32'(x_done), 32'd0);
    chk("R1 missed", 32'(missed), 32'd0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R1 idle vld", 32'(vld), 32'd0);
      chk("R1 idle missed", 32'(missed), 32'd0);
      @(negedge clk);
    end

    // R5/R6/R4 sweep: both modes, two stride sets
    for (int m = 0; m < 2; m++)
      for (int st = 0; st < 2; st++)
        for (int a = 1; a <= 3; a++)
          for (int b = 1; b <= 3; b++)
            for (int c = 1; c <= 3; c++) begin
              if (st == 0)
                do_arm(m[0], a, b, c, 16'd3, 16'hFFFE, 16'd20, 16'hFF00);
              else
                do_arm(m[0], a, b, c, 16'(a), 16'hFFFB, 16'(a * b), 16'd100);
              run_block(m[0] ? "R6 frame sync" : "R5 array sync");
            end

    // R9/R10 mid-stream trigger, clear, and same-cycle set+clear
    do_arm(1'b1, 2, 3, 2, 16'd2, 16'd2, 16'd8, 16'd8);
    run_unit(3, 1'b0, "R9 miss", 2, 1'b1, 1'b0, 1'b0);
    chk("R9 missed set", 32'(missed), 32'd1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R10 cleared", 32'(missed), 32'd0);
    run_unit(3, 1'b1, "R10 set wins", 1, 1'b1, 1'b1, 1'b0);
    chk("R10 set wins over clear", 32'(missed), 32'd1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R10 cleared again", 32'(missed), 32'd0);

    // R11 arm during a run is ignored
    do_arm(1'b0, 3, 2, 2, 16'd4, 16'd4, 16'd16, 16'd16);
    run_unit(1, 1'b0, "R11 arm ignored", 1, 1'b0, 1'b0, 1'b1);
    run_unit(1, 1'b0, "R11 config kept", -1, 1'b0, 1'b0, 1'b0);

    // R2 zero length leaves the channel idle
    do_arm(1'b1, 2, 2, 2, 16'd2, 16'd2, 16'd4, 16'd4);
    do_arm(1'b1, 2, 2, 0, 16'd2, 16'd2, 16'd4, 16'd4);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R2 no pairs", 32'(vld), 32'd0);
      chk("R2 no done", 32'(u_done), 32'd0);
      @(negedge clk);
    end
    chk("R2 missed untouched", 32'(missed), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule